// File: doc/BRIEF.md
# Priority Level Interrupt Controller

This block sits between a set of peripheral interrupt lines and a CPU core. Each maskable source owns an enable bit, a latched pending flag and a programmable priority. The block also takes one non-maskable line. At every instruction boundary it picks the strongest eligible request. A maskable request is taken only when its priority beats the CPU's current mask level.

On acceptance the block does four things in one cycle. It emits a one-cycle accept pulse with a vector number. It raises the mask level to the accepted priority, or to the top level for the non-maskable line. It clears the trace flag and drops the winner's pending flag. When the handler returns, the CPU reloads the mask level and trace flag through a restore port. Stack handling and vector-table reads belong to the CPU.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, accept is 0, mask_level is 7 (all ones), trace_flag is 0, and every source is disabled with priority 0 and no pending flag.
- R2: A cycle with cfg_we high writes cfg_en and cfg_prio into the source numbered cfg_sel.
- R3: A high irq_in bit sets that source's pending flag. A pending source competes only while its enable is 1. A disabled pending source stays pending and is taken once it is enabled.
- R4: Among eligible sources, the one with the highest priority wins, and the others stay pending.
- R5: Among eligible sources of equal priority, the lowest source index wins.
- R6: A maskable winner is accepted only when its priority is strictly greater than mask_level. Otherwise it stays pending.
- R7: A pending non-maskable request is accepted regardless of mask_level, including level 7. It wins over any maskable request.
- R8: Acceptance happens only at a rising edge where insn_done is 1. accept is high for the cycle after that edge.
- R9: On acceptance, mask_level takes the accepted priority (7 for the non-maskable request) and trace_flag becomes 0.
- R10: accept_vec is VEC_BASE (default 16) plus the source index for a maskable source, and NMI_VEC (default 7) for the non-maskable one.
- R11: The accepted source's pending flag is cleared, so the same request is not taken twice.
- R12: A cycle with restore_we high loads restore_mask into mask_level and restore_trace into trace_flag, and no acceptance happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | IDX_W | Source index written |
| cfg_en | input | 1 | Enable value written |
| cfg_prio | input | PRIO_W | Priority value written |
| irq_in | input | NUM_SRC | Maskable request pulses, one bit per source |
| nmi_in | input | 1 | Non-maskable request pulse |
| insn_done | input | 1 | Instruction-boundary strobe |
| restore_we | input | 1 | Reload strobe for mask level and trace flag |
| restore_mask | input | PRIO_W | Mask level to reload |
| restore_trace | input | 1 | Trace flag to reload |
| accept | output | 1 | One-cycle acceptance pulse |
| accept_vec | output | VEC_W | Vector number of the accepted request |
| mask_level | output | PRIO_W | Current mask level |
| trace_flag | output | 1 | Current trace flag |

## Verification
The bench sets the mask equal to a request's priority, where a design that compared with greater-or-equal would accept too early. It holds requests with no boundary strobe, which exposes a design that accepts mid-instruction. It raises equal-priority sources and a non-maskable request beside a maskable one at mask level 7, which catches a wrong tie order or a non-maskable line that is subject to masking. It also fires a restore and a boundary in the same cycle, and repeats boundaries after an acceptance, so a pending flag that is never cleared shows up as a second accept.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   // Order used when two eligible sources carry the same priority
   typedef enum logic {
      TIE_LOW_INDEX  = 1'b0,
      TIE_HIGH_INDEX = 1'b1
   } tie_order_e;

   // Build the vector number of a maskable source
   function automatic logic [15:0] src_vector(input int base, input int idx);
      return 16'(base + idx);
   endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 3,
   parameter int IDX_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [IDX_W-1:0]          cfg_sel,
   input  logic                      cfg_en,
   input  logic [PRIO_W-1:0]         cfg_prio,
   input  logic [NUM_SRC-1:0]        irq_in,
   input  logic                      clr_valid,
   input  logic [IDX_W-1:0]          clr_idx,
   output logic [NUM_SRC-1:0]        en_o,
   output logic [NUM_SRC-1:0]        pend_o,
   output logic [NUM_SRC*PRIO_W-1:0] prio_o
);

   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] clr_hit;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic [PRIO_W-1:0] prio_q;
      logic              sel_hit;

      assign sel_hit    = cfg_we && (cfg_sel == IDX_W'(g));
      assign clr_hit[g] = clr_valid && (clr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q[g]   <= 1'b0;
            prio_q    <= '0;
            pend_q[g] <= 1'b0;
         end else begin
            if (sel_hit) begin
               en_q[g] <= cfg_en;
               prio_q  <= cfg_prio;
            end
            // a fresh pulse outranks the clear of an acceptance
            if (irq_in[g])
               pend_q[g] <= 1'b1;
            else if (clr_hit[g])
               pend_q[g] <= 1'b0;
         end
      end

      assign prio_o[g*PRIO_W +: PRIO_W] = prio_q;

      // R11: after a clear with no new pulse the flag is gone
      a_r11_pend_dropped: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_hit[g] && !irq_in[g]) |=> !pend_q[g]);
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;

   // R11: only a pending, enabled source may be cleared
   a_r11_clear_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
      clr_valid |-> (pend_q[clr_idx] && en_q[clr_idx]));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import prio_irq_pkg::*;
#(
   parameter int         NUM_SRC   = 8,
   parameter int         PRIO_W    = 3,
   parameter int         IDX_W     = 3,
   parameter tie_order_e TIE_ORDER = TIE_LOW_INDEX
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        en_i,
   input  logic [NUM_SRC-1:0]        pend_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   output logic                      win_any,
   output logic [IDX_W-1:0]          win_idx,
   output logic [PRIO_W-1:0]         win_prio
);

   logic [NUM_SRC-1:0] elig;
   logic [PRIO_W-1:0]  prio_a [NUM_SRC];
   int                 scan_a [NUM_SRC];

   assign elig = en_i & pend_i;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
      assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
      // later scan positions win ties, so the preferred index goes last
      if (TIE_ORDER == TIE_LOW_INDEX) begin : g_low
         assign scan_a[g] = NUM_SRC - 1 - g;
      end else begin : g_high
         assign scan_a[g] = g;
      end
   end

   always_comb begin
      win_any  = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (elig[scan_a[k]] && (!win_any || prio_a[scan_a[k]] >= win_prio)) begin
            win_any  = 1'b1;
            win_idx  = IDX_W'(scan_a[k]);
            win_prio = prio_a[scan_a[k]];
         end
      end
   end

   for (genvar j = 0; j < NUM_SRC; j++) begin : g_chk
      // R4: no eligible source outranks the winner
      a_r4_winner_is_max: assert property (@(posedge clk) disable iff (!rst_n)
         elig[j] |-> (win_any && prio_a[j] <= win_prio));
      // R5: an equal-priority rival never sits earlier in the tie order
      if (TIE_ORDER == TIE_LOW_INDEX) begin : g_tl
         a_r5_tie_order: assert property (@(posedge clk) disable iff (!rst_n)
            (elig[j] && prio_a[j] == win_prio) |-> (IDX_W'(j) >= win_idx));
      end else begin : g_th
         a_r5_tie_order: assert property (@(posedge clk) disable iff (!rst_n)
            (elig[j] && prio_a[j] == win_prio) |-> (IDX_W'(j) <= win_idx));
      end
   end

endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
   import prio_irq_pkg::*;
#(
   parameter int PRIO_W   = 3,
   parameter int IDX_W    = 3,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 16,
   parameter int NMI_VEC  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_done,
   input  logic              nmi_in,
   input  logic              restore_we,
   input  logic [PRIO_W-1:0] restore_mask,
   input  logic              restore_trace,
   input  logic              win_any,
   input  logic [IDX_W-1:0]  win_idx,
   input  logic [PRIO_W-1:0] win_prio,
   output logic              clr_valid,
   output logic [IDX_W-1:0]  clr_idx,
   output logic              accept,
   output logic [VEC_W-1:0]  accept_vec,
   output logic [PRIO_W-1:0] mask_level,
   output logic              trace_flag
);

   localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);

   logic              nmi_pend_q;
   logic              acc_q;
   logic [VEC_W-1:0]  vec_q;
   logic [PRIO_W-1:0] mask_q;
   logic              trace_q;
   logic              past_ok;
   logic              slot_open;
   logic              take_nmi;
   logic              take_mask;
   logic [VEC_W-1:0]  mask_vec;

   assign slot_open = insn_done && !restore_we;
   assign take_nmi  = slot_open && nmi_pend_q;
   assign take_mask = slot_open && !nmi_pend_q && win_any && (win_prio > mask_q);
   assign mask_vec  = VEC_W'(src_vector(VEC_BASE, int'(win_idx)));

   assign clr_valid = take_mask;
   assign clr_idx   = win_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_pend_q <= 1'b0;
         acc_q      <= 1'b0;
         vec_q      <= '0;
         mask_q     <= '1;
         trace_q    <= 1'b0;
         past_ok    <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         acc_q   <= take_nmi || take_mask;
         if (nmi_in)
            nmi_pend_q <= 1'b1;
         else if (take_nmi)
            nmi_pend_q <= 1'b0;
         if (restore_we) begin
            mask_q  <= restore_mask;
            trace_q <= restore_trace;
         end else if (take_nmi) begin
            mask_q  <= '1;
            trace_q <= 1'b0;
            vec_q   <= NMI_V;
         end else if (take_mask) begin
            mask_q  <= win_prio;
            trace_q <= 1'b0;
            vec_q   <= mask_vec;
         end
      end
   end

   assign accept     = acc_q;
   assign accept_vec = vec_q;
   assign mask_level = mask_q;
   assign trace_flag = trace_q;

   // R8: an acceptance follows a boundary strobe
   a_r8_at_boundary: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      acc_q |-> $past(insn_done));
   // R6: a maskable acceptance always lifts the mask
   a_r6_mask_rises: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (acc_q && vec_q != NMI_V) |-> (mask_q > $past(mask_q)));
   // R7: the non-maskable acceptance leaves the top level
   a_r7_nmi_top: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q && vec_q == NMI_V) |-> (mask_q == '1));
   // R9: trace is off right after any acceptance
   a_r9_trace_off: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q |-> !trace_q);
   // R12: a restore cycle loads the level and accepts nothing
   a_r12_restore: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $past(restore_we) |-> (!acc_q && mask_q == $past(restore_mask)));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int         NUM_SRC   = 8,
   parameter int         PRIO_W    = 3,
   parameter int         VEC_W     = 8,
   parameter int         VEC_BASE  = 16,
   parameter int         NMI_VEC   = 7,
   parameter tie_order_e TIE_ORDER = TIE_LOW_INDEX,
   localparam int        IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_sel,
   input  logic               cfg_en,
   input  logic [PRIO_W-1:0]  cfg_prio,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               nmi_in,
   input  logic               insn_done,
   input  logic               restore_we,
   input  logic [PRIO_W-1:0]  restore_mask,
   input  logic               restore_trace,
   output logic               accept,
   output logic [VEC_W-1:0]   accept_vec,
   output logic [PRIO_W-1:0]  mask_level,
   output logic               trace_flag
);

   localparam int VEC_SPAN = 1 << VEC_W;

   if (NUM_SRC < 2) begin : g_bad_src
      $error("NUM_SRC must be at least 2");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must lie in 1..8");
   end
   if (VEC_W < 2 || VEC_W > 16 || VEC_BASE + NUM_SRC > VEC_SPAN) begin : g_bad_vec
      $error("vector range does not fit VEC_W");
   end
   if (NMI_VEC >= VEC_SPAN || (NMI_VEC >= VEC_BASE && NMI_VEC < VEC_BASE + NUM_SRC)) begin : g_bad_nmi
      $error("NMI_VEC must fit and stay outside the maskable range");
   end

   logic [NUM_SRC-1:0]        en_w;
   logic [NUM_SRC-1:0]        pend_w;
   logic [NUM_SRC*PRIO_W-1:0] prio_w;
   logic                      win_any;
   logic [IDX_W-1:0]          win_idx;
   logic [PRIO_W-1:0]         win_prio;
   logic                      clr_valid;
   logic [IDX_W-1:0]          clr_idx;

   irq_src_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
      .irq_in(irq_in), .clr_valid(clr_valid), .clr_idx(clr_idx),
      .en_o(en_w), .pend_o(pend_w), .prio_o(prio_w)
   );

   irq_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W),
                 .TIE_ORDER(TIE_ORDER)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .en_i(en_w), .pend_i(pend_w), .prio_i(prio_w),
      .win_any(win_any), .win_idx(win_idx), .win_prio(win_prio)
   );

   irq_mask_unit #(.PRIO_W(PRIO_W), .IDX_W(IDX_W), .VEC_W(VEC_W),
                   .VEC_BASE(VEC_BASE), .NMI_VEC(NMI_VEC)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .insn_done(insn_done), .nmi_in(nmi_in),
      .restore_we(restore_we), .restore_mask(restore_mask), .restore_trace(restore_trace),
      .win_any(win_any), .win_idx(win_idx), .win_prio(win_prio),
      .clr_valid(clr_valid), .clr_idx(clr_idx),
      .accept(accept), .accept_vec(accept_vec),
      .mask_level(mask_level), .trace_flag(trace_flag)
   );

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

   localparam int NSRC = 8;
   localparam int VB   = 16;
   localparam int NV   = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [2:0]      cfg_sel = '0;
   logic            cfg_en = 1'b0;
   logic [2:0]      cfg_prio = '0;
   logic [NSRC-1:0] irq_in = '0;
   logic            nmi_in = 1'b0;
   logic            insn_done = 1'b0;
   logic            restore_we = 1'b0;
   logic [2:0]      restore_mask = '0;
   logic            restore_trace = 1'b0;
   logic            accept;
   logic [7:0]      accept_vec;
   logic [2:0]      mask_level;
   logic            trace_flag;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
      .irq_in(irq_in), .nmi_in(nmi_in), .insn_done(insn_done),
      .restore_we(restore_we), .restore_mask(restore_mask), .restore_trace(restore_trace),
      .accept(accept), .accept_vec(accept_vec),
      .mask_level(mask_level), .trace_flag(trace_flag)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // every task is entered just after a falling edge and leaves on one
   task automatic cfg(input int idx, input bit en, input int prio);
      cfg_we = 1'b1; cfg_sel = 3'(idx); cfg_en = en; cfg_prio = 3'(prio);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input logic [NSRC-1:0] bits, input bit nmi);
      irq_in = bits; nmi_in = nmi;
      @(negedge clk);
      irq_in = '0; nmi_in = 1'b0;
   endtask

   task automatic restore(input int m, input bit t);
      restore_we = 1'b1; restore_mask = 3'(m); restore_trace = t;
      @(negedge clk);
      restore_we = 1'b0;
   endtask

   task automatic boundary();
      insn_done = 1'b1;
      @(negedge clk);
      insn_done = 1'b0;
   endtask

   task automatic expect_take(input string tag, input int vec, input int mask);
      boundary();
      chk({tag, " accept"}, int'(accept), 1);
      chk({tag, " vector"}, int'(accept_vec), vec);
      chk({tag, " mask"}, int'(mask_level), mask);
      chk({tag, " trace"}, int'(trace_flag), 0);
   endtask

   task automatic expect_none(input string tag);
      boundary();
      chk({tag, " no accept"}, int'(accept), 0);
   endtask

   task automatic t_reset();
      chk("R1 accept", int'(accept), 0);
      chk("R1 mask", int'(mask_level), 7);
      chk("R1 trace", int'(trace_flag), 0);
      restore(0, 1'b0);
      pulse('1, 1'b0);
      expect_none("R1 all disabled");
   endtask

   task automatic t_mask_compare();
      cfg(2, 1'b1, 3);
      pulse(8'h04, 1'b0);
      restore(3, 1'b0);
      expect_none("R6 equal level");
      restore(2, 1'b1);
      chk("R12 trace loaded", int'(trace_flag), 1);
      expect_take("R6 R9 R10 src2", VB + 2, 3);
      expect_none("R11 cleared");
   endtask

   task automatic t_boundary();
      restore(0, 1'b0);
      cfg(5, 1'b1, 4);
      pulse(8'h20, 1'b0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R8 no strobe", int'(accept), 0);
      end
      expect_take("R8 strobe", VB + 5, 4);
      @(negedge clk);
      chk("R8 single pulse", int'(accept), 0);
   endtask

   task automatic t_priority();
      cfg(1, 1'b1, 2);
      cfg(6, 1'b1, 6);
      cfg(3, 1'b1, 5);
      pulse(8'h4A, 1'b0);
      restore(0, 1'b0);
      expect_take("R4 first", VB + 6, 6);
      restore(0, 1'b0);
      expect_take("R4 second", VB + 3, 5);
      restore(0, 1'b0);
      expect_take("R4 third", VB + 1, 2);
   endtask

   task automatic t_tie();
      cfg(0, 1'b1, 4);
      cfg(4, 1'b1, 4);
      pulse(8'h11, 1'b0);
      restore(0, 1'b0);
      expect_take("R5 low index", VB + 0, 4);
      restore(0, 1'b0);
      expect_take("R5 remaining", VB + 4, 4);
   endtask

   task automatic t_enable();
      cfg(7, 1'b0, 7);
      pulse(8'h80, 1'b0);
      restore(0, 1'b0);
      expect_none("R3 disabled");
      cfg(7, 1'b1, 7);
      expect_take("R3 R2 enabled later", VB + 7, 7);
   endtask

   task automatic t_nmi();
      cfg(3, 1'b1, 6);
      pulse(8'h08, 1'b1);
      expect_take("R7 at level 7", NV, 7);
      restore(0, 1'b0);
      expect_take("R7 maskable after", VB + 3, 6);
      pulse(8'h02, 1'b1);
      restore(0, 1'b1);
      expect_take("R7 beats maskable", NV, 7);
      restore(0, 1'b0);
      expect_take("R7 leftover", VB + 1, 2);
   endtask

   task automatic t_restore();
      pulse(8'h04, 1'b0);
      restore_we = 1'b1; restore_mask = 3'd1; restore_trace = 1'b1;
      insn_done = 1'b1;
      @(negedge clk);
      restore_we = 1'b0; insn_done = 1'b0;
      chk("R12 blocks accept", int'(accept), 0);
      chk("R12 mask", int'(mask_level), 1);
      chk("R12 trace", int'(trace_flag), 1);
      expect_take("R12 next boundary", VB + 2, 3);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask_compare();
      t_boundary();
      t_priority();
      t_tie();
      t_enable();
      t_nmi();
      t_restore();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule